// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

The block collects single-bit event inputs into five 32-bit banks. Each bank holds an enable register and a latched status register. An event sets its status bit. A source is pending when its status bit and its enable bit are both 1. Banks 0 to 2 carry functional events and drive one combined functional interrupt. Banks 3 and 4 carry error events and drive a separate combined error interrupt. Both outputs are level-sensitive.

Software uses a plain synchronous register port. It sets or clears enable bits by read-modify-write, and it acknowledges a source by writing 1 to its status bit. Each group also reports the lowest-numbered pending source, so a handler can service sources in a fixed order without scanning the banks. Sources are numbered by bit position, bank × 32 + bit. Bank 2 and bank 4 are only partly populated, so their top bits are holes in the numbering.

Top module: `bank_irq_aggr`

## Requirements
- R1: After reset, every enable and status register reads 0, both interrupt outputs are low and both valid flags are low.
- R2: Populated widths per bank are 32, 32, 24, 32 and 17 bits. Unpopulated bits always read 0 in both registers and never become pending, even when their event input is high or 1s are written to them.
- R3: A source number is bank × 32 + bit. For example, bit 0 of bank 3 is source 96 and bit 8 of bank 1 is source 40.
- R4: An enable bit of 1 unmasks its source and 0 masks it. A masked source never drives an output or an index.
- R5: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A status bit set by an event stays set until it is cleared.
- R6: fn_irq_o is high exactly when some source in banks 0 to 2 has both its status bit and its enable bit set.
- R7: err_irq_o is high exactly when some source in banks 3 and 4 is pending, independently of the functional banks.
- R8: Each index output gives the pending source of its group with the lowest bank, and within that bank the lowest bit.
- R9: Each output stays high until every pending source of its group has been cleared or masked.
- R10: A status bit sets on any clock edge at which its event input is high. If an event and a write-1-to-clear reach the same bit on the same edge, the bit stays set.
- R11: Masking a source keeps its status bit. Re-enabling a source whose status bit is still latched asserts the group output again on the next cycle.
- R12: Each valid flag is high exactly when its group has at least one pending source. The index is meaningful only while its flag is high.
- R13: Register map: address 2k selects the enable register of bank k and address 2k+1 selects the status register of bank k, for k = 0 to 4. Addresses 10 to 15 read 0, and writes to them have no effect. Writes take effect at the clock edge. Read data follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 160 | Event inputs, bit n is source n |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| fn_irq_o | output | 1 | Functional group interrupt |
| fn_idx_vld_o | output | 1 | Functional index valid |
| fn_idx_o | output | 8 | Lowest pending functional source |
| err_irq_o | output | 1 | Error group interrupt |
| err_idx_vld_o | output | 1 | Error index valid |
| err_idx_o | output | 8 | Lowest pending error source |

## Verification
The assertions check the following on every cycle:
- unpopulated status bits stay 0;
- an event is always latched on the next cycle, even against a clear;
- a status bit never falls without a status write;
- each valid flag agrees with its interrupt line;
- each index falls inside its own group's range.

Some behaviour shows only in the bench's scenarios, which compare the design against a behavioural model every cycle:
- the lowest-first ordering across banks;
- masking without losing status, and reassertion on re-enable;
- the address decode, including writes to unused addresses.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;
  localparam int unsigned NUM_BANKS = 5;
  localparam int unsigned FN_BANKS  = 3;
  localparam int unsigned BANK_W    = 32;

  // populated bits per bank; holes are forced to zero
  function automatic logic [BANK_W-1:0] pop_mask(int unsigned bank);
    case (bank)
      2:       pop_mask = 32'h00FF_FFFF;
      4:       pop_mask = 32'h0001_FFFF;
      default: pop_mask = (bank < NUM_BANKS) ? '1 : '0;
    endcase
  endfunction
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POP = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         ctrl_we_i,
  input  logic         stat_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] clr;

  assign clr    = stat_we_i ? wdata_i : '0;
  assign pend_o = ctrl_o & stat_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      stat_o <= '0;
    end else begin
      if (ctrl_we_i) ctrl_o <= wdata_i & POP;
      // set has priority over clear
      stat_o <= (stat_o & ~clr) | (evt_i & POP);
    end
  end
endmodule

// File: rtl/irq_pri_enc.sv
module irq_pri_enc #(
  parameter int unsigned N     = 96,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned BASE  = 0
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(BASE + i);
      end
    end
  end
endmodule

// File: rtl/bank_irq_aggr.sv
module bank_irq_aggr
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NB     = NUM_BANKS,
  parameter int unsigned NFB    = FN_BANKS,
  localparam int unsigned W     = BANK_W,
  localparam int unsigned SRC_W = NB * W,
  localparam int unsigned FN_W  = NFB * W,
  localparam int unsigned ERR_W = SRC_W - FN_W,
  localparam int unsigned IDX_W = $clog2(SRC_W),
  localparam int unsigned ADR_W = $clog2(2 * NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] evt_i,
  input  logic             reg_we_i,
  input  logic [ADR_W-1:0] reg_addr_i,
  input  logic [W-1:0]     reg_wdata_i,
  output logic [W-1:0]     reg_rdata_o,
  output logic             fn_irq_o,
  output logic             fn_idx_vld_o,
  output logic [IDX_W-1:0] fn_idx_o,
  output logic             err_irq_o,
  output logic             err_idx_vld_o,
  output logic [IDX_W-1:0] err_idx_o
);
  logic [NB-1:0][W-1:0] ctrl_q, stat_q, pend;
  logic [SRC_W-1:0]     stat_flat, pend_flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic ctrl_we, stat_we;
    assign ctrl_we = reg_we_i && (reg_addr_i == ADR_W'(2 * b));
    assign stat_we = reg_we_i && (reg_addr_i == ADR_W'(2 * b + 1));

    irq_bank #(.W(W), .POP(pop_mask(b))) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .evt_i     (evt_i[b*W +: W]),
      .ctrl_we_i (ctrl_we),
      .stat_we_i (stat_we),
      .wdata_i   (reg_wdata_i),
      .ctrl_o    (ctrl_q[b]),
      .stat_o    (stat_q[b]),
      .pend_o    (pend[b])
    );
    assign stat_flat[b*W +: W] = stat_q[b];
    assign pend_flat[b*W +: W] = pend[b];
  end

  assign fn_irq_o  = |pend_flat[FN_W-1:0];
  assign err_irq_o = |pend_flat[SRC_W-1:FN_W];

  irq_pri_enc #(.N(FN_W), .IDX_W(IDX_W), .BASE(0)) u_fn_enc (
    .req_i (pend_flat[FN_W-1:0]),
    .any_o (fn_idx_vld_o),
    .idx_o (fn_idx_o)
  );

  irq_pri_enc #(.N(ERR_W), .IDX_W(IDX_W), .BASE(FN_W)) u_err_enc (
    .req_i (pend_flat[SRC_W-1:FN_W]),
    .any_o (err_idx_vld_o),
    .idx_o (err_idx_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < int'(NB); b++) begin
      if (reg_addr_i == ADR_W'(2 * b))     reg_rdata_o = ctrl_q[b];
      if (reg_addr_i == ADR_W'(2 * b + 1)) reg_rdata_o = stat_q[b];
    end
  end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
  import irq_aggr_pkg::*;
#(
  parameter int unsigned NB    = NUM_BANKS,
  parameter int unsigned NFB   = FN_BANKS,
  parameter int unsigned SRC_W = NUM_BANKS * BANK_W,
  parameter int unsigned IDX_W = 8,
  parameter int unsigned ADR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SRC_W-1:0] evt_i,
  input logic             reg_we_i,
  input logic [ADR_W-1:0] reg_addr_i,
  input logic [SRC_W-1:0] stat_flat,
  input logic             fn_irq_o,
  input logic             fn_idx_vld_o,
  input logic [IDX_W-1:0] fn_idx_o,
  input logic             err_irq_o,
  input logic             err_idx_vld_o,
  input logic [IDX_W-1:0] err_idx_o
);
  localparam int unsigned FN_W = NFB * BANK_W;

  logic [SRC_W-1:0] pop_flat, evt_pop;
  logic             stat_wr;

  for (genvar b = 0; b < NB; b++) begin : g_pop
    assign pop_flat[b*BANK_W +: BANK_W] = pop_mask(b);
  end
  assign evt_pop = evt_i & pop_flat;
  assign stat_wr = reg_we_i && reg_addr_i[0] && (int'(reg_addr_i) < int'(2 * NB));

  assert_holes_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_flat & ~pop_flat) == '0);

  assert_event_latched_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_flat & $past(evt_pop)) == $past(evt_pop)));

  assert_no_fall_without_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> (($past(stat_flat) & ~stat_flat) == '0));

  assert_fn_valid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_idx_vld_o == fn_irq_o);

  assert_err_valid_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_idx_vld_o == err_irq_o);

  assert_fn_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fn_idx_vld_o |-> (int'(fn_idx_o) < int'(FN_W)));

  assert_err_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_idx_vld_o |-> (int'(err_idx_o) >= int'(FN_W)));
endmodule

bind bank_irq_aggr irq_aggr_chk #(
  .NB(NB), .NFB(NFB), .SRC_W(SRC_W), .IDX_W(IDX_W), .ADR_W(ADR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt_i         (evt_i),
  .reg_we_i      (reg_we_i),
  .reg_addr_i    (reg_addr_i),
  .stat_flat     (stat_flat),
  .fn_irq_o      (fn_irq_o),
  .fn_idx_vld_o  (fn_idx_vld_o),
  .fn_idx_o      (fn_idx_o),
  .err_irq_o     (err_irq_o),
  .err_idx_vld_o (err_idx_vld_o),
  .err_idx_o     (err_idx_o)
);

// File: tb/bank_irq_aggr_tb.sv
module bank_irq_aggr_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [159:0] evt_i = '0;
  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [31:0]  reg_rdata_o;
  logic         fn_irq_o, fn_idx_vld_o, err_irq_o, err_idx_vld_o;
  logic [7:0]   fn_idx_o, err_idx_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [31:0] m_ctrl [5];
  logic [31:0] m_stat [5];

  always #5 clk_i = ~clk_i;

  bank_irq_aggr u_dut (
    .clk_i, .rst_ni, .evt_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .fn_irq_o, .fn_idx_vld_o, .fn_idx_o,
    .err_irq_o, .err_idx_vld_o, .err_idx_o
  );

  function automatic logic [31:0] mpop(int b);
    int cnt;
    cnt = (b == 2) ? 24 : (b == 4) ? 17 : 32;
    return (cnt == 32) ? 32'hFFFF_FFFF : ((32'd1 << cnt) - 32'd1);
  endfunction

  function automatic void cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 5; b++) begin
      m_ctrl[b] = '0;
      m_stat[b] = '0;
    end
  endtask

  task automatic compare(string tag);
    int fn_i = -1, er_i = -1;
    logic [31:0] rd;
    for (int b = 4; b >= 0; b--)
      for (int i = 31; i >= 0; i--)
        if (m_ctrl[b][i] && m_stat[b][i]) begin
          if (b < 3) fn_i = b * 32 + i;
          else er_i = b * 32 + i;
        end
    rd = (reg_addr_i < 10) ? (reg_addr_i[0] ? m_stat[reg_addr_i >> 1] : m_ctrl[reg_addr_i >> 1]) : '0;
    cmp(tag, "fn_irq", int'(fn_irq_o), int'(fn_i >= 0));
    cmp(tag, "fn_vld", int'(fn_idx_vld_o), int'(fn_i >= 0));
    if (fn_i >= 0) cmp(tag, "fn_idx", int'(fn_idx_o), fn_i);
    cmp(tag, "err_irq", int'(err_irq_o), int'(er_i >= 0));
    cmp(tag, "err_vld", int'(err_idx_vld_o), int'(er_i >= 0));
    if (er_i >= 0) cmp(tag, "err_idx", int'(err_idx_o), er_i);
    cmp(tag, "rdata", int'(reg_rdata_o), int'(rd));
  endtask

  // drive at negedge, model updates at posedge, compare at next negedge
  task automatic step(string tag, bit we, logic [3:0] addr, logic [31:0] wd, logic [159:0] ev);
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd; evt_i = ev;
    @(posedge clk_i);
    for (int b = 0; b < 5; b++) begin
      logic [31:0] clr;
      clr = (we && addr == 4'(2 * b + 1)) ? wd : '0;
      if (we && addr == 4'(2 * b)) m_ctrl[b] = wd & mpop(b);
      m_stat[b] = (m_stat[b] & ~clr) | (ev[b*32 +: 32] & mpop(b));
    end
    @(negedge clk_i);
    reg_we_i = 1'b0; evt_i = '0;
    compare(tag);
  endtask

  task automatic rd(string tag, logic [3:0] addr);
    step(tag, 1'b0, addr, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    compare("R1_in_reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 0; a < 10; a++) rd("R1_after_reset", 4'(a));

    // enable everything; holes read back 0
    for (int b = 0; b < 5; b++) step("R13_ctrl_write", 1'b1, 4'(2 * b), 32'hFFFF_FFFF, '0);
    rd("R2_ctrl_hole_b2", 4'd4);
    rd("R2_ctrl_hole_b4", 4'd8);

    // all events at once
    step("R6_R7_all_events", 1'b0, 4'd5, '0, '1);
    rd("R2_stat_hole_b2", 4'd5);
    rd("R2_stat_hole_b4", 4'd9);
    rd("R8_lowest_first", 4'd1);

    // acknowledge banks one at a time
    step("R5_clear_b0", 1'b1, 4'd1, 32'hFFFF_FFFF, '0);
    step("R5_zero_write_noop", 1'b1, 4'd3, 32'h0, '0);
    rd("R5_readback_b1", 4'd3);
    step("R9_clear_b1", 1'b1, 4'd3, 32'hFFFF_FFFF, '0);
    step("R9_clear_b2", 1'b1, 4'd5, 32'hFFFF_FFFF, '0);
    rd("R7_err_still_up", 4'd7);

    // mask bank 3, status kept, re-enable
    step("R4_mask_b3", 1'b1, 4'd6, 32'h0, '0);
    rd("R11_stat_kept", 4'd7);
    step("R11_reenable_b3", 1'b1, 4'd6, 32'hFFFF_FFFF, '0);

    // set and clear on same bit: set wins
    step("R10_set_wins", 1'b1, 4'd7, 32'h0000_0001, 160'd1 << 96);
    rd("R10_readback", 4'd7);
    step("R9_clear_b3", 1'b1, 4'd7, 32'hFFFF_FFFF, '0);
    step("R9_clear_b4", 1'b1, 4'd9, 32'hFFFF_FFFF, '0);
    rd("R12_nothing_pending", 4'd9);

    // numbering and ordering
    step("R3_src40", 1'b0, 4'd3, '0, 160'd1 << 40);
    step("R8_src20_lower", 1'b0, 4'd1, '0, 160'd1 << 20);
    step("R4_mask_bit20", 1'b1, 4'd0, ~(32'd1 << 20), '0);
    step("R3_src96_err", 1'b0, 4'd7, '0, 160'd1 << 96);
    step("R3_src130_err", 1'b0, 4'd9, '0, 160'd1 << 130);
    step("R8_clear96", 1'b1, 4'd7, 32'h1, '0);

    // unpopulated event bit
    step("R2_hole_event", 1'b0, 4'd5, '0, 160'd1 << 90);
    step("R2_hole_event_b4", 1'b0, 4'd9, '0, 160'd1 << 150);

    // unused addresses
    step("R13_unused_write", 1'b1, 4'd12, 32'hFFFF_FFFF, '0);
    rd("R13_unused_read", 4'd12);
    rd("R13_unused_read15", 4'd15);
    rd("R13_ctrl_b0_intact", 4'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule